// File: doc/BRIEF.md
# Strap-addressed I2C slave with persistent register pointer

This block is a clock-oversampled I2C target that opens a bank of up to sixteen 8-bit registers to a bus master. The device address has a fixed upper part, 001. Its lower four bits come from two three-level strap inputs, so up to eight such targets can share one bus. Every target also accepts a shared broadcast write address.

The first byte written after the address is a command byte. Its low four bits load a register pointer. The next byte is written to the register the pointer selects. A read sets the pointer in the same way, then uses a repeated START to return that register. The pointer is kept between transactions, so a bare read addressed to the device returns the last selected register.

Both bus lines are sampled on the system clock. SDA is driven only through an active-high pull-down enable. The register file sits outside the block and is reached through a simple port: a pointer, a one-cycle write strobe and a combinational read return.

Top module: `i2cp_slave`

## Requirements
- R1: While reset is held, `sda_pull_o` and `reg_wr_o` are 0. After reset the block keeps SDA released until it is addressed.
- R2: Each strap input reads 2'b00 as low (value 0), 2'b01 as high (value 1), and 2'b10 or 2'b11 as open (value 2). Let index = 3*A + B. The device address is {3'b001, code[3:0]}, where code = index for index 0 and code = index-1 for index 2 to 8. Address bytes carrying this address are acknowledged. Other addresses are not acknowledged.
- R3: The strap setting A low with B high (index 1) gives the device no individual address. It then responds only to the broadcast write address.
- R4: The broadcast address 7'b0011111 is acknowledged with R/W=0 for any strap setting. It is not acknowledged with R/W=1.
- R5: After an acknowledged write address, the low four bits of the first data byte appear on `reg_addr_o`. The block acknowledges that byte.
- R6: The second data byte of a write is acknowledged. It produces exactly one single-cycle `reg_wr_o` pulse, carrying that byte on `reg_wdata_o` and the pointer on `reg_addr_o`.
- R7: Any further bytes in the same write are acknowledged and produce no write strobe.
- R8: A repeated START followed by the device address with R/W=1 is acknowledged. It is followed by the selected register, MSB first.
- R9: If the master acknowledges a read byte, the same register is sent again. After a master NACK, SDA stays released until the next START.
- R10: The pointer survives STOP. A later read addressed to the device, with no command byte, returns the register last selected.
- R11: A START or STOP at any bit position abandons the current byte. SDA is released on STOP, and a START begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pin |
| sda_i | input | 1 | Bus data as seen at the pin |
| sda_pull_o | output | 1 | 1 = drive SDA low |
| strap_a_i | input | 2 | First three-level address strap |
| strap_b_i | input | 2 | Second three-level address strap |
| reg_addr_o | output | PTR_W | Register pointer |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for the pointed register |

## Verification
Errors in the bit counter or the byte-kind state show up at the ports within one byte time. They appear as an acknowledge in the wrong slot, a misplaced write strobe, or a data bit shifted by one. A corrupt pointer only becomes visible later, on the next write strobe or read. For that reason the bench reads back through receive-byte transactions after STOP, which exposes a pointer that fails to persist. A state left dangling after an aborted byte would show on the transaction that follows the START or STOP that should have cleared it, as a wrong acknowledge or a stray write.

// File: rtl/i2cp_pkg.sv
// Shared types and constants for the strap-addressed I2C slave.
// Assumes 8-bit bus bytes and a fixed 3-bit upper address part.
package i2cp_pkg;
    localparam int BYTE_W = 8;
    localparam logic [2:0] ADDR_HI = 3'b001;
    localparam logic [6:0] BCAST_ADDR = 7'b0011111;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_MACK, ST_WAIT
    } eng_st_t;

    typedef enum logic [1:0] {
        K_ADDR, K_CMD, K_DATA, K_XTRA
    } byte_kind_t;

    // Map a strap code to its level: low=0, high=1, open=2
    function automatic logic [1:0] strap_level(input logic [1:0] s);
        case (s)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/i2cp_sync.sv
// Synchronises SCL and SDA to clk and derives edge, START and STOP pulses.
// Assumes the system clock runs well above the SCL rate.
module i2cp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    // Shift both bus lines through the synchroniser and keep one old copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Decode line events from the current and previous samples
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cp_addr.sv
// Turns the two three-level straps into the device address.
// Assumes straps are static while the bus is in use.
module i2cp_addr
    import i2cp_pkg::*;
(
    input  logic [1:0] strap_a,
    input  logic [1:0] strap_b,
    output logic [6:0] own_addr,
    output logic       own_valid
);
    logic [3:0] idx;
    logic [3:0] code;

    // Combine the two levels and skip the reserved combination
    always_comb begin
        idx       = 4'(strap_level(strap_a)) * 4'd3 + 4'(strap_level(strap_b));
        own_valid = (idx != 4'd1);
        code      = (idx > 4'd1) ? idx - 4'd1 : idx;
        own_addr  = {ADDR_HI, code};
    end
endmodule

// File: rtl/i2cp_engine.sv
// Byte engine: receives address/command/data bytes, drives ACK and read
// data, and holds the persistent register pointer.
// Assumes event pulses from i2cp_sync; at most one event per cycle.
module i2cp_engine
    import i2cp_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        own_addr,
    input  logic              own_valid,
    output logic              sda_pull,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] rdata
);
    eng_st_t     st;
    byte_kind_t  kind;
    logic [2:0]        cnt;
    logic [BYTE_W-1:0] rx_sr, tx_sr, rx_byte;
    logic              rw_q, ack_pend, mack_q;
    logic              hit_own, hit_bcast;

    // Assemble the byte as it will stand at the eighth rising edge
    always_comb begin
        rx_byte   = {rx_sr[BYTE_W-2:0], sda_s};
        hit_own   = own_valid && (rx_byte[7:1] == own_addr);
        hit_bcast = (rx_byte[7:1] == BCAST_ADDR) && !rx_byte[0];
    end

    // Main bus state machine with pointer, write strobe and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= K_ADDR;
            cnt      <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rw_q     <= 1'b0;
            ack_pend <= 1'b0;
            mack_q   <= 1'b0;
            sda_pull <= 1'b0;
            ptr      <= '0;
            wr_stb   <= 1'b0;
            wdata    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                st       <= ST_RX;
                kind     <= K_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (st)
                    ST_RX: if (scl_rise) begin
                        rx_sr <= rx_byte;
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            st <= ST_RXEND;
                            case (kind)
                                K_ADDR: begin
                                    ack_pend <= hit_own || hit_bcast;
                                    rw_q     <= rx_byte[0];
                                end
                                K_CMD: begin
                                    ptr      <= rx_byte[PTR_W-1:0];
                                    ack_pend <= 1'b1;
                                end
                                K_DATA: begin
                                    wr_stb   <= 1'b1;
                                    wdata    <= rx_byte;
                                    ack_pend <= 1'b1;
                                end
                                default: ack_pend <= 1'b1;
                            endcase
                        end
                    end
                    ST_RXEND: if (scl_fall) begin
                        st       <= ack_pend ? ST_ACK : ST_WAIT;
                        sda_pull <= ack_pend;
                    end
                    ST_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (kind == K_ADDR && rw_q) begin
                            st       <= ST_TX;
                            tx_sr    <= rdata;
                            sda_pull <= ~rdata[7];
                        end else begin
                            st       <= ST_RX;
                            sda_pull <= 1'b0;
                            case (kind)
                                K_ADDR:  kind <= K_CMD;
                                K_CMD:   kind <= K_DATA;
                                default: kind <= K_XTRA;
                            endcase
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (cnt == 3'd7) begin
                            st       <= ST_MACK;
                            sda_pull <= 1'b0;
                        end else begin
                            cnt      <= cnt + 3'd1;
                            tx_sr    <= {tx_sr[BYTE_W-2:0], 1'b0};
                            sda_pull <= ~tx_sr[6];
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall) begin
                            if (mack_q) begin
                                st       <= ST_TX;
                                cnt      <= '0;
                                tx_sr    <= rdata;
                                sda_pull <= ~rdata[7];
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cp_slave.sv
// Top of the strap-addressed I2C slave: synchroniser, address decode and
// byte engine. Assumes clk is at least 8x SCL and an open-drain pad outside.
module i2cp_slave
    import i2cp_pkg::*;
#(
    parameter int PTR_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [1:0]        strap_a_i,
    input  logic [1:0]        strap_b_i,
    output logic [PTR_W-1:0]  reg_addr_o,
    output logic              reg_wr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] own_addr;
    logic       own_valid;

    i2cp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2cp_addr u_addr (
        .strap_a(strap_a_i), .strap_b(strap_b_i),
        .own_addr(own_addr), .own_valid(own_valid)
    );

    i2cp_engine #(.PTR_W(PTR_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .own_valid(own_valid), .sda_pull(sda_pull_o),
        .ptr(reg_addr_o), .wr_stb(reg_wr_o), .wdata(reg_wdata_o),
        .rdata(reg_rdata_i)
    );

    logic unused_scl;
    assign unused_scl = scl_s;
endmodule

// File: rtl/i2cp_chk.sv
// Protocol checker for i2cp_slave, attached with bind below.
// Assumes event pulses taken from the synchroniser instance.
module i2cp_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_pull,
    input logic             reg_wr,
    input logic [PTR_W-1:0] reg_addr,
    input logic             scl_fall,
    input logic             stop_det
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!sda_pull && !reg_wr));

    // R6
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5
    ptr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $stable(reg_addr));

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // R9
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));
endmodule

bind i2cp_slave i2cp_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull_o), .reg_wr(reg_wr_o),
    .reg_addr(reg_addr_o), .scl_fall(scl_fall), .stop_det(stop_det)
);

// File: tb/sim_i2cp_slave.sv
// Bench: behavioural bus master, register-file model and an expected-write
// queue compared on every clock.
module sim_i2cp_slave;
    localparam int T = 25;
    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap_a = 2'b10, strap_b = 2'b00;
    logic sda_pull, reg_wr;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [16];
    logic [11:0] expq[$];
    int checks = 0, fails = 0;
    bit done = 0;
    wire sda_bus = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    i2cp_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .strap_a_i(strap_a), .strap_b_i(strap_b),
        .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
        .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Per-clock comparison of write strobes against the model queue (R6, R7)
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            if (expq.size() == 0) chk(0, "R7 unexpected write", {reg_addr, reg_wdata}, 0);
            else begin
                logic [11:0] e;
                e = expq.pop_front();
                chk({reg_addr, reg_wdata} == e, "R6 write addr/data", {reg_addr, reg_wdata}, e);
            end
        end
    end

    task automatic w(input int n); repeat (n) @(negedge clk); endtask
    task automatic bstart(); sda_m = 1; w(T); scl_m = 1; w(T); sda_m = 0; w(T); scl_m = 0; endtask
    task automatic bstop(); sda_m = 0; w(T); scl_m = 1; w(T); sda_m = 1; w(T); endtask
    task automatic bbit(input bit b, output bit r);
        sda_m = b; w(T); scl_m = 1; w(T); r = sda_bus; scl_m = 0;
    endtask
    task automatic sendb(input logic [7:0] b, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) bbit(b[i], r);
        bbit(1'b1, r);
        ack = !r;
    endtask
    task automatic readb(input bit mack, output logic [7:0] d);
        bit r;
        for (int i = 7; i >= 0; i--) begin bbit(1'b1, r); d[i] = r; end
        bbit(!mack, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit a;
        bit r;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        w(3);
        chk(!sda_pull && !reg_wr, "R1 reset outputs", {sda_pull, reg_wr}, 0);
        rst_n = 1; w(10);
        chk(!sda_pull, "R1 idle release", sda_pull, 0);

        // Straps open/low -> index 6 -> code 5 -> address 0x15
        bstart(); sendb(8'h28, a); chk(!a, "R2 foreign address nack", a, 0); bstop();
        bstart(); sendb(8'h2A, a); chk(a, "R2 own address ack", a, 1);
        sendb(8'h13, a); chk(a, "R5 command ack", a, 1);
        w(2); chk(reg_addr == 4'h3, "R5 pointer low bits", reg_addr, 3);
        expq.push_back({4'h3, 8'hA5});
        sendb(8'hA5, a); chk(a, "R6 data ack", a, 1);
        sendb(8'h5A, a); chk(a, "R7 extra byte ack", a, 1);
        bstop();
        chk(mem[3] == 8'hA5, "R7 register kept", mem[3], 8'hA5);

        // Read word with repeated START
        bstart(); sendb(8'h2A, a); sendb(8'h03, a);
        bstart(); sendb(8'h2B, a); chk(a, "R8 read address ack", a, 1);
        readb(1, d); chk(d == 8'hA5, "R8 first read byte", d, 8'hA5);
        readb(0, d); chk(d == 8'hA5, "R9 repeated byte", d, 8'hA5);
        w(6); chk(!sda_pull, "R9 release after nack", sda_pull, 0);
        bstop();

        // Receive byte with persistent pointer
        mem[3] = 8'hC3;
        bstart(); sendb(8'h2B, a); readb(0, d); bstop();
        chk(d == 8'hC3, "R10 receive byte", d, 8'hC3);
        chk(reg_addr == 4'h3, "R10 pointer kept", reg_addr, 3);

        // Broadcast address
        bstart(); sendb(8'h3E, a); chk(a, "R4 broadcast write ack", a, 1);
        expq.push_back({4'h7, 8'h3C});
        sendb(8'h07, a); sendb(8'h3C, a); bstop();
        chk(mem[7] == 8'h3C, "R4 broadcast write data", mem[7], 8'h3C);
        bstart(); sendb(8'h3F, a); chk(!a, "R4 broadcast read nack", a, 0); bstop();

        // STOP inside an address byte, then a clean write
        bstart(); bbit(0, r); bbit(0, r); bbit(1, r); bbit(0, r); bstop();
        expq.push_back({4'hC, 8'h66});
        bstart(); sendb(8'h2A, a); chk(a, "R11 ack after aborted byte", a, 1);
        sendb(8'h0C, a); sendb(8'h66, a); bstop();
        chk(mem[12] == 8'h66, "R11 write after abort", mem[12], 8'h66);

        // Repeated START inside a data byte
        bstart(); sendb(8'h2A, a); sendb(8'h02, a);
        bbit(1, r); bbit(0, r); bbit(1, r);
        expq.push_back({4'h4, 8'h11});
        bstart(); sendb(8'h2A, a); chk(a, "R11 restart mid-data", a, 1);
        sendb(8'h04, a); sendb(8'h11, a); bstop();
        chk(mem[2] == 8'h00 && mem[4] == 8'h11, "R11 abandoned byte dropped", {mem[2], mem[4]}, 8'h11);

        // Reserved strap combination
        strap_a = 2'b00; strap_b = 2'b01; w(5);
        bstart(); sendb(8'h20, a); chk(!a, "R3 no individual address 0x10", a, 0); bstop();
        bstart(); sendb(8'h22, a); chk(!a, "R3 no individual address 0x11", a, 0); bstop();
        expq.push_back({4'h9, 8'h77});
        bstart(); sendb(8'h3E, a); chk(a, "R3 broadcast still accepted", a, 1);
        sendb(8'h09, a); sendb(8'h77, a); bstop();
        chk(mem[9] == 8'h77, "R3 broadcast write data", mem[9], 8'h77);

        w(10);
        chk(expq.size() == 0, "R6 all expected writes seen", expq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule